// File: doc/BRIEF.md
# Up/Down Timer Counter with Write-Priority Arbitration

This block is a 16-bit timer counter that steps up or down by one on each clock in which its count enable is high, with the direction chosen by a separate input. A small register bus lets a processor read the counter, load it, read the sticky wrap flags and program their interrupt enables. A bus write is a two-state transaction: the strobe marks the first state (T1), and the captured data is committed at the end of the following clock (T2).

The block defines what happens when a counter load and a count fall in the same cycle. The load always wins. The count in that cycle is discarded, and any overflow or underflow that the count would have caused is not flagged. Outside a collision, an up-count from the top value wraps to zero and raises the overflow flag, and a down-count from zero wraps to the top value and raises the underflow flag. Each flag stays set until software writes a zero to its bit. A level interrupt request is raised while any flag is set and its enable bit is also set.

Top module: `updn_timer`

## Requirements
- R1: While cnt_en is high and no counter load commits, the counter steps by +1 when cnt_up is 1 and by -1 when cnt_up is 0. While cnt_en is low, it holds its value.
- R2: An up-count from 0xFFFF with no load committing gives 0x0000 and sets the overflow flag, which is status bit 0.
- R3: A down-count from 0x0000 with no load committing gives 0xFFFF and sets the underflow flag, which is status bit 1.
- R4: bus_we high for one cycle is state T1 and captures bus_addr and bus_wdata. The write is committed at the clock edge that ends the next cycle (T2). A write to address 0 loads the counter with the data, and a count enabled during T2 is discarded.
- R5: When a counter load commits in the same cycle as a count that would wrap, neither the overflow flag nor the underflow flag is set.
- R6: A write to status (address 1) clears each flag bit written as 0 and leaves each flag bit written as 1 unchanged. If a wrap sets a flag in the same cycle as a clear, the flag ends up set.
- R7: irq is 1 exactly when (status bit 0 AND enable bit 0) OR (status bit 1 AND enable bit 1). The enable register is at address 2 and holds bits 1:0.
- R8: bus_rdata is combinational from bus_addr: address 0 returns the counter, address 1 returns the flags in bits 1:0, address 2 returns the enables in bits 1:0, and address 3 returns zero. Reading does not affect counting or the flags.
- R9: After reset the counter, both flags and both enables are zero, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count qualifier for this cycle |
| cnt_up | input | 1 | 1 = count up, 0 = count down |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe (marks state T1) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check, on every cycle, the single-step count and the hold, the wrap at both ends together with its flag, that a committed load overrides the count, that a load suppresses both wrap events, and that flags stay sticky and win over a same-cycle clear. Other properties only show up in the bench's scenarios. These are the exact two-state timing of a load as seen at the bus, the value sweeps that cross both wrap points, the write-one-has-no-effect rule, the interrupt gating through the enable register, and reads that leave the state untouched.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  localparam int ADDR_W = 2;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_UDF = 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_COUNT  = 2'd0,
    RA_STATUS = 2'd1,
    RA_ENABLE = 2'd2,
    RA_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/updn_wr_stage.sv
module updn_wr_stage
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  pend_data,
  output logic              commit_cnt,
  output logic              commit_st,
  output logic              commit_ie
);
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;

  // T1 captures the transaction, and the cycle after it is T2.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      pend_vld <= bus_we;
      if (bus_we) begin
        pend_addr <= bus_addr;
        pend_data <= bus_wdata;
      end
    end
  end

  assign commit_cnt = pend_vld && (pend_addr == RA_COUNT);
  assign commit_st  = pend_vld && (pend_addr == RA_STATUS);
  assign commit_ie  = pend_vld && (pend_addr == RA_ENABLE);
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             udf_evt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v, input logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  function automatic logic wraps(input logic [CNT_W-1:0] v, input logic up);
    return up ? (v == TOP) : (v == '0);
  endfunction

  logic tick;
  assign tick    = cnt_en && !ld;
  assign ovf_evt = tick && cnt_up && wraps(cnt, 1'b1);
  assign udf_evt = tick && !cnt_up && wraps(cnt, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (tick) cnt <= step(cnt, cnt_up);
  end
endmodule

// File: rtl/updn_flag_reg.sv
module updn_flag_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] evt,
  input  logic       st_wr,
  input  logic       ie_wr,
  input  logic [1:0] wbits,
  output logic [1:0] flags,
  output logic [1:0] ie,
  output logic       irq
);
  function automatic logic [1:0] flag_next(input logic [1:0] cur, input logic wr,
                                           input logic [1:0] w, input logic [1:0] set);
    return (cur & (wr ? w : 2'b11)) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ie    <= '0;
    end else begin
      flags <= flag_next(flags, st_wr, wbits, evt);
      if (ie_wr) ie <= wbits;
    end
  end

  assign irq = |(flags & ie);
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  logic [CNT_W-1:0] pend_data;
  logic             commit_cnt, commit_st, commit_ie;
  logic [CNT_W-1:0] cnt;
  logic             ovf_evt, udf_evt;
  logic [1:0]       flags, ie;

  updn_wr_stage #(.CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pend_data(pend_data), .commit_cnt(commit_cnt),
    .commit_st(commit_st), .commit_ie(commit_ie)
  );

  updn_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .ld(commit_cnt), .ld_val(pend_data), .cnt(cnt),
    .ovf_evt(ovf_evt), .udf_evt(udf_evt)
  );

  updn_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .evt({udf_evt, ovf_evt}), .st_wr(commit_st),
    .ie_wr(commit_ie), .wbits(pend_data[1:0]), .flags(flags), .ie(ie), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_COUNT:  bus_rdata = cnt;
      RA_STATUS: bus_rdata[1:0] = flags;
      RA_ENABLE: bus_rdata[1:0] = ie;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             cnt_up,
  input logic [CNT_W-1:0] cnt,
  input logic             commit_cnt,
  input logic             commit_st,
  input logic [CNT_W-1:0] pend_data,
  input logic             ovf_evt,
  input logic             udf_evt,
  input logic [1:0]       flags
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && cnt_up && !commit_cnt && cnt != TOP |=> cnt == $past(cnt) + 1'b1); // R1
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !cnt_up && !commit_cnt && cnt != '0 |=> cnt == $past(cnt) - 1'b1); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !commit_cnt |=> $stable(cnt)); // R1
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && cnt_up && !commit_cnt && cnt == TOP |=> cnt == '0 && flags[0]); // R2
  AST_UDF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !cnt_up && !commit_cnt && cnt == '0 |=> cnt == TOP && flags[1]); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_cnt |=> cnt == $past(pend_data)); // R4
  AST_NO_WRAP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit_cnt |-> !ovf_evt && !udf_evt); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !commit_st |=> flags[0]); // R6
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] && !commit_st |=> flags[1]); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[0]); // R6
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up), .cnt(cnt),
  .commit_cnt(commit_cnt), .commit_st(commit_st), .pend_data(pend_data),
  .ovf_evt(ovf_evt), .udf_evt(udf_evt), .flags(flags)
);

// File: tb/updn_timer_tb.sv
module updn_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, cnt_up = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  updn_timer u_dut (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  // T1 at the next edge, commit at the edge after; t2_en drives cnt_en during T2.
  task automatic wr(input logic [1:0] a, input logic [15:0] d,
                    input logic t2_en = 1'b0, input logic t2_up = 1'b1);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d; cnt_en = 1'b0;
    @(negedge clk); bus_we = 1'b0; cnt_en = t2_en; cnt_up = t2_up;
    @(negedge clk); cnt_en = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic run(input int n, input logic up);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1'b1; cnt_up = up;
    end
    @(negedge clk); cnt_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] starts [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R9 counter", v, 16'h0);
    rd(2'd1, v); check("R9 flags", v, 16'h0);
    rd(2'd2, v); check("R9 enables", v, 16'h0);
    check("R9 irq", {15'd0, irq}, 16'h0);
    rst_n = 1'b1;

    // R4 commit timing: value not visible after T1, visible after T2
    @(negedge clk); bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 16'hA5A5;
    @(negedge clk); bus_we = 1'b0; #1; check("R4 not yet after T1", bus_rdata, 16'h0);
    @(negedge clk); #1; check("R4 loaded after T2", bus_rdata, 16'hA5A5);

    // R1/R2/R3/R8 sweep: start, direction, steps; read every step
    foreach (starts[s]) for (int d = 0; d < 2; d++) for (int n = 0; n < 5; n++) begin
      logic [16:0] e;
      logic expw;
      wr(2'd1, 16'h0);
      wr(2'd0, starts[s]);
      for (int k = 0; k < n; k++) begin
        @(negedge clk); cnt_en = 1'b1; cnt_up = d[0];
      end
      @(negedge clk); cnt_en = 1'b0;
      e = d[0] ? {1'b0, starts[s]} + 17'(n) : {1'b0, starts[s]} - 17'(n);
      expw = d[0] ? ({1'b0, starts[s]} + 17'(n) > 17'hFFFF) : (17'(n) > {1'b0, starts[s]});
      rd(2'd0, v); check("R1 sweep count", v, e[15:0]);
      rd(2'd1, v);
      check(d[0] ? "R2 sweep flag" : "R3 sweep flag", v, d[0] ? {15'd0, expw} : {14'd0, expw, 1'b0});
      rd(2'd0, v); check("R8 read no effect", v, e[15:0]);
    end

    // R5 collision: load during T2 with a would-be overflow / underflow
    wr(2'd1, 16'h0); wr(2'd0, 16'hFFFF);
    wr(2'd0, 16'h1234, 1'b1, 1'b1);
    rd(2'd0, v); check("R4 load beats up-count", v, 16'h1234);
    rd(2'd1, v); check("R5 no overflow on collision", v, 16'h0);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h4321, 1'b1, 1'b0);
    rd(2'd0, v); check("R4 load beats down-count", v, 16'h4321);
    rd(2'd1, v); check("R5 no underflow on collision", v, 16'h0);

    // R6 sticky, write-1 no effect, set wins
    wr(2'd0, 16'hFFFF); run(1, 1'b1);
    wr(2'd0, 16'h0000); run(1, 1'b0);
    rd(2'd1, v); check("R6 both set", v, 16'h3);
    wr(2'd1, 16'h0003); rd(2'd1, v); check("R6 write one no effect", v, 16'h3);
    check("R7 irq off without enable", {15'd0, irq}, 16'h0);
    wr(2'd2, 16'h0002); #1; check("R7 irq via underflow enable", {15'd0, irq}, 16'h1);
    rd(2'd2, v); check("R7 enable readback", v, 16'h2);
    wr(2'd1, 16'h0001); rd(2'd1, v); check("R6 clear bit1 only", v, 16'h1);
    #1; check("R7 irq drops", {15'd0, irq}, 16'h0);
    wr(2'd2, 16'h0001); #1; check("R7 irq via overflow enable", {15'd0, irq}, 16'h1);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0000, 1'b1, 1'b1);
    rd(2'd1, v); check("R6 set wins over clear", v, 16'h1);
    rd(2'd0, v); check("R2 wrap beside status write", v, 16'h0);
    wr(2'd1, 16'h0000); rd(2'd1, v); check("R6 clear by zero", v, 16'h0);
    rd(2'd3, v); check("R8 spare reads zero", v, 16'h0);
    run(3, 1'b0); rd(2'd0, v); check("R1 hold after count", v, 16'hFFFD);
    repeat (3) @(negedge clk); rd(2'd0, v); check("R1 hold idle", v, 16'hFFFD);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule